// File: doc/BRIEF.md
# NAND Flash Bus Controller

This block sits between a simple register bus and an 8-bit NAND flash device. Software configures a chip-select level, an enable and three strobe timing values. It then writes commands, addresses and data bytes through dedicated register offsets. Each such write becomes one timed write cycle on the flash pins. The command-latch or address-latch line is held high for the whole cycle as required.

A read of the data offset runs one timed read cycle. The bus access is held until the byte captured from the device can be returned. A status offset lets software poll the device ready line, for example after issuing the reset command 0xFF. Writing the ECC-reset bit of the configuration word emits a single-cycle clear pulse for an external ECC engine. While a flash cycle is in progress, every bus access is stalled through a wait signal.

Top module: `nand_if_ctrl`

## Requirements
- R1: After reset the configuration reads 0x0800, the chip enable is high, both strobes are high, both latch lines are low and the bus is not stalled.
- R2: The configuration word at offset 0x00 keeps bits 15 (enable), 11 (chip enable level), 10:8 (setup), 6:4 (active) and 2:0 (hold); every other bit reads 0. The chip enable pin equals bit 11 (0 = low, active).
- R3: A configuration write with bit 12 set raises the ECC clear output for exactly one clock. No other access raises it.
- R4: With the block enabled, a write to offset 0x04 makes one write-strobe pulse. The command-latch line is high and the address-latch line is low during the pulse, and the flash data bus carries the low byte of the written value.
- R5: With the block enabled, a write to offset 0x08 makes one write-strobe pulse. The address-latch line is high and the command-latch line is low, and the flash data bus carries the written byte.
- R6: With the block enabled, a write to offset 0x0C makes one write-strobe pulse with both latch lines low, carrying the written byte.
- R7: With the block enabled, a read of offset 0x0C makes one read-strobe pulse with the flash data bus not driven. It returns in bits 7:0 the byte present on the flash data input during the last active clock, with bits 15:8 zero.
- R8: A write cycle spends setup clocks with strobes high, then holds the strobe low for active+1 clocks, then stays stalled for hold+1 clocks. The bus wait output is high for that whole span. For a data read, the access is stalled for one extra clock before the setup phase.
- R9: A read of offset 0x10 returns the device ready input in bit 0 and zero elsewhere.
- R10: With configuration bit 15 clear, accesses to offsets 0x04, 0x08 and 0x0C produce no strobe and no stall, and a data read returns 0.
- R11: The write and read strobes are never low at the same time.
- R12: Offset 0x14 reads 0 and writes to it change no state and start no cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid when the access completes |
| bus_wait | output | 1 | Access stall; an access completes in a cycle with bus_sel high and bus_wait low |
| nf_ce_n | output | 1 | Flash chip enable, active low |
| nf_cle | output | 1 | Command-latch enable |
| nf_ale | output | 1 | Address-latch enable |
| nf_we_n | output | 1 | Write strobe, active low |
| nf_re_n | output | 1 | Read strobe, active low |
| nf_io_out | output | IO_W | Byte driven to the flash |
| nf_io_oe | output | 1 | Output enable for nf_io_out |
| nf_io_in | input | IO_W | Byte read from the flash |
| nf_rdy | input | 1 | Device ready/busy line |
| ecc_clr | output | 1 | One-clock ECC clear pulse |

## Verification
A phase counter that loads or decrements wrongly shows up in the count of clocks the strobe spends low or the stall lasts after it. That error is visible within the same cycle. A kind latched wrongly at launch shows up as the wrong latch line in the first clock of the cycle. A lost or stuck read-completion flag either hangs the data read on the wait signal or returns the previous byte on the next data read. The bench measures setup, pulse and hold lengths per cycle over several timing settings, so such faults show within one access.

// File: rtl/nand_if_ctrl.sv
module nand_if_ctrl #(
  parameter int IO_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_sel,
  input  logic            bus_wr,
  input  logic [4:0]      bus_addr,
  input  logic [15:0]     bus_wdata,
  output logic [15:0]     bus_rdata,
  output logic            bus_wait,
  output logic            nf_ce_n,
  output logic            nf_cle,
  output logic            nf_ale,
  output logic            nf_we_n,
  output logic            nf_re_n,
  output logic [IO_W-1:0] nf_io_out,
  output logic            nf_io_oe,
  input  logic [IO_W-1:0] nf_io_in,
  input  logic            nf_rdy,
  output logic            ecc_clr
);

  localparam logic [4:0]  A_CFG = 5'h00, A_CMD = 5'h04, A_ADR = 5'h08,
                          A_DAT = 5'h0C, A_STA = 5'h10;
  localparam logic [15:0] CFG_MASK = 16'h8F77;
  localparam logic [15:0] CFG_RST  = 16'h0800;

  typedef enum logic [1:0] {S_IDLE, S_SETUP, S_ACT, S_HOLD} phase_t;

  phase_t          st;
  logic [2:0]      cnt;
  logic            op_cle, op_ale, op_rd, rd_done;
  logic [IO_W-1:0] op_byte, rd_buf;
  logic [15:0]     cfg_q;

  wire       en     = cfg_q[15];
  wire [2:0] t_set  = cfg_q[10:8];
  wire [2:0] t_act  = cfg_q[6:4];
  wire [2:0] t_hold = cfg_q[2:0];

  wire fl_reg  = (bus_addr == A_CMD) || (bus_addr == A_ADR) || (bus_addr == A_DAT);
  wire fl_acc  = bus_sel && en && fl_reg;
  wire rd_pend = fl_acc && !bus_wr && (bus_addr == A_DAT) && !rd_done;
  wire busy    = (st != S_IDLE);
  wire take    = bus_sel && !bus_wait;
  wire cfg_wr  = take && bus_wr && (bus_addr == A_CFG);
  wire launch  = !busy && fl_acc && (bus_wr || !rd_done);

  assign bus_wait  = busy || rd_pend;
  assign nf_ce_n   = cfg_q[11];
  assign nf_we_n   = !(st == S_ACT && !op_rd);
  assign nf_re_n   = !(st == S_ACT && op_rd);
  assign nf_cle    = busy && op_cle;
  assign nf_ale    = busy && op_ale;
  assign nf_io_oe  = busy && !op_rd;
  assign nf_io_out = op_byte;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CFG: bus_rdata = cfg_q;
      A_DAT: if (en) bus_rdata[IO_W-1:0] = rd_buf;
      A_STA: bus_rdata[0] = nf_rdy;
      default: bus_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      op_cle  <= 1'b0;
      op_ale  <= 1'b0;
      op_rd   <= 1'b0;
      op_byte <= '0;
      rd_buf  <= '0;
      rd_done <= 1'b0;
      cfg_q   <= CFG_RST;
      ecc_clr <= 1'b0;
    end else begin
      ecc_clr <= cfg_wr && bus_wdata[12];
      if (cfg_wr) cfg_q <= bus_wdata & CFG_MASK;
      if (take && fl_acc) rd_done <= 1'b0;
      case (st)
        S_IDLE: if (launch) begin
          op_cle  <= (bus_addr == A_CMD);
          op_ale  <= (bus_addr == A_ADR);
          op_rd   <= !bus_wr;
          op_byte <= bus_wdata[IO_W-1:0];
          if (t_set == 3'd0) begin
            st  <= S_ACT;
            cnt <= t_act;
          end else begin
            st  <= S_SETUP;
            cnt <= t_set - 3'd1;
          end
        end
        S_SETUP: if (cnt == 3'd0) begin
          st  <= S_ACT;
          cnt <= t_act;
        end else cnt <= cnt - 3'd1;
        S_ACT: if (cnt == 3'd0) begin
          st  <= S_HOLD;
          cnt <= t_hold;
          if (op_rd) rd_buf <= nf_io_in;
        end else cnt <= cnt - 3'd1;
        S_HOLD: if (cnt == 3'd0) begin
          st <= S_IDLE;
          if (op_rd) rd_done <= 1'b1;
        end else cnt <= cnt - 3'd1;
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_ECC_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    ecc_clr |=> !ecc_clr); // R3
  AST_ECC_FROM_CFG: assert property (@(posedge clk) disable iff (!rst_n)
    ecc_clr |-> $past(bus_sel && bus_wr && bus_addr == A_CFG && bus_wdata[12])); // R3
  AST_LATCH_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(nf_cle && nf_ale)); // R4
  AST_IO_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!nf_we_n && $past(!nf_we_n)) |-> $stable(nf_io_out)); // R4
  AST_STROBE_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    (!nf_we_n || !nf_re_n) |-> bus_wait); // R8
  AST_NO_DUAL_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    nf_we_n || nf_re_n); // R11
  AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_wait) |-> $stable(cfg_q)); // R8

endmodule

// File: tb/nand_if_ctrl_bench.sv
module nand_if_ctrl_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [4:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic bus_wait, nf_ce_n, nf_cle, nf_ale, nf_we_n, nf_re_n, nf_io_oe, ecc_clr;
  logic [7:0] nf_io_out;
  logic [7:0] nf_io_in = '0;
  logic nf_rdy = 1'b1;

  int checks = 0, errors = 0, ecc_cnt = 0;
  int m_set, m_pulse, m_hold, m_dual, m_cle, m_ale, m_oe;
  logic [7:0] m_io;
  logic [15:0] m_rd;
  bit done = 0;

  always #10 clk = ~clk;

  nand_if_ctrl #(.IO_W(8)) u_nand_if_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_wait(bus_wait), .nf_ce_n(nf_ce_n), .nf_cle(nf_cle), .nf_ale(nf_ale),
    .nf_we_n(nf_we_n), .nf_re_n(nf_re_n), .nf_io_out(nf_io_out),
    .nf_io_oe(nf_io_oe), .nf_io_in(nf_io_in), .nf_rdy(nf_rdy), .ecc_clr(ecc_clr));

  always @(negedge clk) if (ecc_clr) ecc_cnt++;

  // op: 0 command, 1 address, 2 data write, 3 data read
  localparam int NV = 7;
  localparam logic [18:0] VEC [NV] = '{
    {2'd0, 3'd0, 3'd0, 3'd0, 8'hFF},
    {2'd0, 3'd2, 3'd1, 3'd3, 8'h70},
    {2'd1, 3'd1, 3'd2, 3'd0, 8'h5A},
    {2'd2, 3'd7, 3'd7, 3'd7, 8'hC3},
    {2'd3, 3'd3, 3'd0, 3'd2, 8'h96},
    {2'd3, 3'd0, 3'd4, 3'd0, 8'h3C},
    {2'd2, 3'd0, 3'd0, 3'd1, 8'h01}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic sample();
    if (!nf_we_n && !nf_re_n) m_dual++;
    if (!nf_we_n || !nf_re_n) begin
      m_pulse++;
      m_cle = nf_cle; m_ale = nf_ale; m_oe = nf_io_oe; m_io = nf_io_out;
    end else if (m_pulse == 0) m_set++;
    else m_hold++;
  endtask

  task automatic xfer(input bit wr, input logic [4:0] a, input logic [15:0] d);
    int guard;
    m_set = 0; m_pulse = 0; m_hold = 0; m_dual = 0;
    m_cle = 0; m_ale = 0; m_oe = 0; m_io = '0;
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = wr; bus_addr = a; bus_wdata = d;
    #1;
    guard = 0;
    while (bus_wait && guard < 200) begin
      sample(); @(negedge clk); #1; guard++;
    end
    m_rd = bus_rdata;
    @(posedge clk); #1;
    bus_sel = 1'b0;
    @(negedge clk);
    guard = 0;
    while (bus_wait && guard < 200) begin
      sample(); @(negedge clk); guard++;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(nf_ce_n === 1'b1 && nf_we_n === 1'b1 && nf_re_n === 1'b1, "R1 strobes/ce",
        {nf_ce_n, nf_we_n, nf_re_n}, 3'b111);
    chk(nf_cle === 1'b0 && nf_ale === 1'b0 && bus_wait === 1'b0, "R1 latch/wait",
        {nf_cle, nf_ale, bus_wait}, 0);
    rst_n = 1'b1;
    xfer(1'b0, 5'h00, 16'h0);
    chk(m_rd == 16'h0800, "R1 cfg reset", m_rd, 16'h0800);

    // R2 config mask and chip enable level
    xfer(1'b1, 5'h00, 16'hEFFF);
    xfer(1'b0, 5'h00, 16'h0);
    chk(m_rd == 16'h8F77, "R2 cfg readback", m_rd, 16'h8F77);
    chk(nf_ce_n === 1'b1, "R2 ce_n high", nf_ce_n, 1);
    xfer(1'b1, 5'h00, 16'h8000);
    chk(nf_ce_n === 1'b0, "R2 ce_n low", nf_ce_n, 0);

    // R3 ecc strobe
    ecc_cnt = 0;
    xfer(1'b1, 5'h00, 16'h9000);
    repeat (3) @(negedge clk);
    chk(ecc_cnt == 1, "R3 ecc pulse once", ecc_cnt, 1);
    xfer(1'b0, 5'h00, 16'h0);
    chk(m_rd[12] == 1'b0, "R3 bit12 not stored", m_rd, 16'h8000);
    ecc_cnt = 0;
    xfer(1'b1, 5'h00, 16'h8000);
    xfer(1'b1, 5'h04, 16'h10FF);
    repeat (3) @(negedge clk);
    chk(ecc_cnt == 0, "R3 no pulse otherwise", ecc_cnt, 0);

    // Table walk: R4 R5 R6 R7 R8 R11
    for (int i = 0; i < NV; i++) begin
      logic [1:0] op;
      logic [2:0] ts, ta, th;
      logic [7:0] dv;
      {op, ts, ta, th, dv} = VEC[i];
      xfer(1'b1, 5'h00, {1'b1, 4'b0, ts, 1'b0, ta, 1'b0, th});
      if (op == 2'd3) begin
        nf_io_in = dv;
        xfer(1'b0, 5'h0C, 16'h0);
        chk(m_rd == {8'h00, dv}, "R7 read data", m_rd, dv);
        chk(m_oe == 0 && m_cle == 0 && m_ale == 0, "R7 bus released", {m_oe, m_cle, m_ale}, 0);
        chk(m_set == ts + 1 && m_pulse == ta + 1 && m_hold == th + 1, "R8 read timing",
            m_set * 256 + m_pulse * 16 + m_hold, (ts + 1) * 256 + (ta + 1) * 16 + th + 1);
        nf_io_in = ~dv;
      end else begin
        xfer(1'b1, op == 2'd0 ? 5'h04 : op == 2'd1 ? 5'h08 : 5'h0C, {8'hA5, dv});
        chk(m_set == ts && m_pulse == ta + 1 && m_hold == th + 1, "R8 write timing",
            m_set * 256 + m_pulse * 16 + m_hold, ts * 256 + (ta + 1) * 16 + th + 1);
        chk(m_io == dv && m_oe == 1, "R4 R5 R6 byte driven", m_io, dv);
        if (op == 2'd0) chk(m_cle == 1 && m_ale == 0, "R4 command latch", {m_cle, m_ale}, 2'b10);
        if (op == 2'd1) chk(m_cle == 0 && m_ale == 1, "R5 address latch", {m_cle, m_ale}, 2'b01);
        if (op == 2'd2) chk(m_cle == 0 && m_ale == 0, "R6 data latch", {m_cle, m_ale}, 2'b00);
      end
      chk(m_dual == 0, "R11 dual strobe", m_dual, 0);
    end

    // R9 status
    nf_rdy = 1'b0;
    xfer(1'b0, 5'h10, 16'h0);
    chk(m_rd == 16'h0000, "R9 busy", m_rd, 0);
    nf_rdy = 1'b1;
    xfer(1'b0, 5'h10, 16'h0);
    chk(m_rd == 16'h0001, "R9 ready", m_rd, 1);

    // R12 unused offset
    xfer(1'b1, 5'h00, 16'h8123);
    xfer(1'b1, 5'h14, 16'hFFFF);
    chk(m_pulse == 0 && m_set == 0, "R12 no cycle", m_pulse, 0);
    xfer(1'b0, 5'h14, 16'h0);
    chk(m_rd == 16'h0000, "R12 reads zero", m_rd, 0);
    xfer(1'b0, 5'h00, 16'h0);
    chk(m_rd == 16'h8123, "R12 cfg untouched", m_rd, 16'h8123);

    // R10 disabled
    xfer(1'b1, 5'h00, 16'h0111);
    xfer(1'b1, 5'h04, 16'h0090);
    chk(m_pulse == 0 && m_set == 0 && m_hold == 0, "R10 cmd ignored", m_pulse, 0);
    xfer(1'b1, 5'h08, 16'h0011);
    chk(m_pulse == 0 && m_set == 0, "R10 addr ignored", m_pulse, 0);
    nf_io_in = 8'h77;
    xfer(1'b0, 5'h0C, 16'h0);
    chk(m_pulse == 0 && m_set == 0 && m_rd == 16'h0, "R10 data read", m_rd, 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule